// File: doc/BRIEF.md
# Compare-Match Timer with Output Pin

This block is a 10-bit up-counter with two comparators. It keeps one interrupt request flag for each comparator and drives one output pin. Comparator A checks the whole count against a 10-bit compare value. Comparator P checks a coarse period: a 3-bit value set against the top three count bits. A select bit chooses which comparator restarts the counter, and that choice also decides which flags can fire. When the chosen compare value is zero, the counter runs over its full range instead.

The pin reacts only to comparator A. On an A hit it can hold, go low, go high or toggle. When the enable input rises, the pin is loaded with a programmed start level. A 2-bit mode field is decoded, and the timer runs only in compare-output mode (code 00). Every control is a plain level or strobe pin. There is no data stream, so there is no handshake and no back-pressure.

Top module: `cmp_timer`

## Requirements
- R1: While `rst_n` is low, and on the first sample after its release, `count` is 0, both flags are 0 and `pin_out` is 0.
- R2: The timer runs when `enable` is 1 and `mode` is 00. While it runs and no clear applies, `count` rises by one per clock edge and wraps from 0x3FF to 0.
- R3: With `clr_sel` = 0 and `cmp_p` ≠ 0, a count equal to `{cmp_p, 7'b0}` is a P hit. On the next edge the counter becomes 0 and `flag_p` sets.
- R4: With `clr_sel` = 0 and `cmp_p` = 0, the counter runs to 0x3FF and wraps to 0. The P hit is taken at count 0x3FF, and `flag_p` sets.
- R5: A count equal to a nonzero `cmp_a` is an A hit under either clear selection, and `flag_a` sets on the next edge. A `cmp_a` of zero never produces an A hit.
- R6: With `clr_sel` = 1, an A hit clears the counter to 0 on the next edge. `flag_p` never sets, even when `cmp_p` lies below `cmp_a`.
- R7: With `clr_sel` = 1 and `cmp_a` = 0, the counter wraps at 0x3FF and `flag_a` does not set.
- R8: `pin_act` is applied on the edge after an A hit: 00 keeps the pin, 01 drives it low, 10 drives it high, 11 toggles it. A P hit never changes the pin.
- R9: On the first clock where `enable` is 1 after being 0, `pin_out` is loaded with `init_lvl`. This load takes priority over any A action in that cycle.
- R10: Each flag stays set until its clear strobe. If a set and a clear strobe arrive in the same cycle, the flag is set.
- R11: While the timer is not running (`enable` = 0, or `mode` ≠ 00), `count` holds and there are no hits. `flag_a`, `flag_p` and `pin_out` keep their values, except for the R9 load and the R10 clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Timer run enable; a rising level loads the pin start level |
| mode | input | 2 | Operating mode; only 00 (compare output) runs the counter |
| clr_sel | input | 1 | 0: P hit clears the counter; 1: A hit clears the counter |
| pin_act | input | 2 | Pin response to an A hit (00 keep, 01 low, 10 high, 11 toggle) |
| init_lvl | input | 1 | Pin level loaded when `enable` rises |
| cmp_a | input | 10 | Comparator A value, full count width |
| cmp_p | input | 3 | Comparator P value, compared with count bits [9:7] |
| clr_flag_a | input | 1 | Clear strobe for `flag_a` |
| clr_flag_p | input | 1 | Clear strobe for `flag_p` |
| count | output | 10 | Current counter value |
| flag_a | output | 1 | Sticky comparator A request flag |
| flag_p | output | 1 | Sticky comparator P request flag |
| pin_out | output | 1 | Timer output pin |

## Verification
The bench targets these corner cases:

- **Zero compare values.** A P value of zero must yield a full 1024-count period with the P hit at 0x3FF. A design that decoded it literally would clear at count 0 and stick there. An A value of zero under A-clear must wrap at 0x3FF without raising `flag_a`.
- **P value below the A value under A-clear.** A design that still raised `flag_p` or cleared on P would be caught here.
- **Pin-action codes.** Each code is exercised, and so is a P hit landing with the pin idle. A swapped low/high decode, or a pin that also reacted to P, shows up on `pin_out`.
- **Enable edge, flag clears and disabled spans.** The bench toggles `enable` so that the start-level load competes with A actions. It holds the flag clear strobes across set events to catch a clear-wins priority. It runs non-compare modes and disabled spans to catch a counter that keeps moving.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned CNT_W_DEF = 10;
  localparam int unsigned PER_W_DEF = 3;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  localparam logic [1:0] MODE_CMP_OUT = 2'b00;

  typedef struct packed {
    logic a_hit;
    logic p_hit;
    logic clear;
  } cmp_evt_t;
endpackage

// File: rtl/cmt_compare.sv
module cmt_compare
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned PER_W = PER_W_DEF
) (
  input  logic             run,
  input  logic             clr_sel,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PER_W-1:0] cmp_p,
  output cmp_evt_t         evt
);
  localparam int unsigned LOW_W = CNT_W - PER_W;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic a_zero, p_zero, a_eq, p_eq;

  always_comb begin
    a_zero = (cmp_a == '0);
    p_zero = (cmp_p == '0);
    a_eq   = (count == cmp_a);
    p_eq   = p_zero ? (count == CNT_TOP) : (count == {cmp_p, {LOW_W{1'b0}}});
    evt.a_hit = run && !a_zero && a_eq;
    evt.p_hit = run && !clr_sel && p_eq;
    if (clr_sel) evt.clear = run && !a_zero && a_eq;
    else         evt.clear = run && !p_zero && p_eq;
  end

  always_comb begin
    if (clr_sel) assert (!evt.p_hit) else $error("p_no_p_hit_r6");
    if (!run)    assert (!evt.a_hit && !evt.clear) else $error("p_idle_no_hit_r11");
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (run) begin
      if (clear)    count <= '0;
      else          count <= count + CNT_W'(1);
    end
  end

  p_clear_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear) |=> (count == $past(count) + CNT_W'(1)));
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));
endmodule

// File: rtl/cmt_flags.sv
module cmt_flags #(
  parameter int unsigned N_FLAGS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set_i,
  input  logic [N_FLAGS-1:0] clr_i,
  output logic [N_FLAGS-1:0] flag_o
);
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[g] <= 1'b0;
      else if (set_i[g])   flag_o[g] <= 1'b1;
      else if (clr_i[g])   flag_o[g] <= 1'b0;
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
  end
endmodule

// File: rtl/cmt_pin.sv
module cmt_pin
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       init_lvl,
  input  logic [1:0] pin_act,
  input  logic       a_hit,
  output logic       pin
);
  logic en_q;
  logic en_rise;
  pin_act_e act;

  always_comb begin
    en_rise = enable && !en_q;
    act     = pin_act_e'(pin_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      pin  <= 1'b0;
    end else begin
      en_q <= enable;
      if (en_rise) pin <= init_lvl;
      else if (a_hit) begin
        unique case (act)
          ACT_KEEP:   pin <= pin;
          ACT_LOW:    pin <= 1'b0;
          ACT_HIGH:   pin <= 1'b1;
          ACT_TOGGLE: pin <= !pin;
        endcase
      end
    end
  end

  p_init_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (pin == $past(init_lvl)));
  p_pin_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_hit && !en_rise) |=> $stable(pin));
  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hit && !en_rise && pin_act == 2'b11) |=> (pin != $past(pin)));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned PER_W = PER_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic             clr_sel,
  input  logic [1:0]       pin_act,
  input  logic             init_lvl,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PER_W-1:0] cmp_p,
  input  logic             clr_flag_a,
  input  logic             clr_flag_p,
  output logic [CNT_W-1:0] count,
  output logic             flag_a,
  output logic             flag_p,
  output logic             pin_out
);
  localparam int unsigned FLAG_A = 0;
  localparam int unsigned FLAG_P = 1;

  logic     run;
  cmp_evt_t evt;
  logic [1:0] fl_set, fl_clr, fl_q;

  always_comb begin
    run            = enable && (mode == MODE_CMP_OUT);
    fl_set[FLAG_A] = evt.a_hit;
    fl_set[FLAG_P] = evt.p_hit;
    fl_clr[FLAG_A] = clr_flag_a;
    fl_clr[FLAG_P] = clr_flag_p;
    flag_a         = fl_q[FLAG_A];
    flag_p         = fl_q[FLAG_P];
  end

  cmt_compare #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmp (
    .run(run), .clr_sel(clr_sel), .count(count),
    .cmp_a(cmp_a), .cmp_p(cmp_p), .evt(evt)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(evt.clear), .count(count)
  );

  cmt_flags #(.N_FLAGS(2)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(fl_set), .clr_i(fl_clr), .flag_o(fl_q)
  );

  cmt_pin u_pin (
    .clk(clk), .rst_n(rst_n), .enable(enable), .init_lvl(init_lvl),
    .pin_act(pin_act), .a_hit(evt.a_hit), .pin(pin_out)
  );

  p_no_p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel && !flag_p) |=> !flag_p);
  p_zero_a_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_a == '0) && !flag_a) |=> !flag_a);
endmodule

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       clr_sel = 1'b0;
  logic [1:0] pin_act = 2'b00;
  logic       init_lvl = 1'b0;
  logic [9:0] cmp_a = '0;
  logic [2:0] cmp_p = '0;
  logic       clr_flag_a = 1'b0;
  logic       clr_flag_p = 1'b0;
  logic [9:0] count;
  logic       flag_a, flag_p, pin_out;

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";

  logic [9:0] m_cnt = '0;
  logic m_fa = 1'b0, m_fp = 1'b0, m_pin = 1'b0, m_enq = 1'b0;

  always #2 clk = !clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .clr_sel(clr_sel),
    .pin_act(pin_act), .init_lvl(init_lvl), .cmp_a(cmp_a), .cmp_p(cmp_p),
    .clr_flag_a(clr_flag_a), .clr_flag_p(clr_flag_p),
    .count(count), .flag_a(flag_a), .flag_p(flag_p), .pin_out(pin_out)
  );

  function automatic logic act_apply(logic [1:0] code, logic cur);
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return !cur;
      default: return cur;
    endcase
  endfunction

  task automatic model_step();
    logic run, a_hit, p_hit, clr, rise;
    logic [9:0] p_pt;
    run   = enable && (mode == 2'b00);
    a_hit = run && (cmp_a != 0) && (m_cnt == cmp_a);
    p_pt  = (cmp_p == 0) ? 10'h3FF : {cmp_p, 7'b0};
    p_hit = run && !clr_sel && (m_cnt == p_pt);
    clr   = clr_sel ? a_hit : (p_hit && cmp_p != 0);
    rise  = enable && !m_enq;
    if (run) m_cnt = clr ? 10'd0 : m_cnt + 10'd1;
    m_fa  = a_hit || (m_fa && !clr_flag_a);
    m_fp  = p_hit || (m_fp && !clr_flag_p);
    m_pin = rise ? init_lvl : (a_hit ? act_apply(pin_act, m_pin) : m_pin);
    m_enq = enable;
  endtask

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("count", 32'(count), 32'(m_cnt));
    check("flag_a", 32'(flag_a), 32'(m_fa));
    check("flag_p", 32'(flag_p), 32'(m_fp));
    check("pin_out", 32'(pin_out), 32'(m_pin));
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic setup(logic en, logic [1:0] md, logic cs, logic [1:0] act,
                       logic il, logic [9:0] a, logic [2:0] p);
    enable = en; mode = md; clr_sel = cs; pin_act = act;
    init_lvl = il; cmp_a = a; cmp_p = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    tag = "R3 P-clear period";
    setup(1, 2'b00, 0, 2'b11, 1, 10'd20, 3'd1);
    step(300);

    tag = "R4 P zero full range";
    clr_flag_p = 1; step(1); clr_flag_p = 0;
    setup(1, 2'b00, 0, 2'b10, 1, 10'd600, 3'd0);
    step(1100);

    tag = "R6 A-clear with P below A";
    clr_flag_p = 1; clr_flag_a = 1; step(1); clr_flag_p = 0; clr_flag_a = 0;
    setup(1, 2'b00, 1, 2'b11, 0, 10'd300, 3'd1);
    step(700);

    tag = "R7 A zero wraps";
    clr_flag_a = 1; step(1); clr_flag_a = 0;
    setup(1, 2'b00, 1, 2'b11, 0, 10'd0, 3'd2);
    step(1100);

    tag = "R8 pin codes";
    setup(1, 2'b00, 1, 2'b00, 0, 10'd9, 3'd0);
    step(40);
    pin_act = 2'b10; step(40);
    pin_act = 2'b01; step(40);
    pin_act = 2'b11; step(40);
    tag = "R8 P hit leaves pin";
    setup(1, 2'b00, 0, 2'b11, 0, 10'd700, 3'd1);
    step(400);

    tag = "R9 enable rise load";
    setup(1, 2'b00, 1, 2'b11, 1, 10'd4, 3'd0);
    for (int k = 0; k < 12; k++) begin
      enable = 0; step(1 + k % 3);
      init_lvl = k[0];
      enable = 1; step(2 + k % 5);
    end

    tag = "R11 idle holds";
    setup(0, 2'b00, 0, 2'b11, 0, 10'd3, 3'd1);
    step(30);
    tag = "R2 non-compare mode";
    setup(1, 2'b01, 0, 2'b11, 0, 10'd3, 3'd1);
    step(30);
    mode = 2'b10; step(10);
    mode = 2'b11; step(10);
    tag = "R2 counting";
    mode = 2'b00; step(50);

    tag = "R10 set wins over clear";
    setup(1, 2'b00, 0, 2'b01, 0, 10'd5, 3'd1);
    clr_flag_a = 1; clr_flag_p = 1;
    step(300);
    clr_flag_a = 0; clr_flag_p = 0;
    step(20);
    clr_flag_a = 1; step(1); clr_flag_a = 0; step(3);

    tag = "R5 random";
    for (int k = 0; k < 600; k++) begin
      enable   = ($urandom % 10) != 0;
      mode     = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      clr_sel  = 1'($urandom);
      pin_act  = 2'($urandom);
      init_lvl = 1'($urandom);
      cmp_a    = (($urandom % 6) == 0) ? 10'd0 : 10'($urandom % 200);
      cmp_p    = 3'($urandom % 3);
      for (int j = 0; j < 40; j++) begin
        clr_flag_a = ($urandom % 8) == 0;
        clr_flag_p = ($urandom % 8) == 0;
        step(1);
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule